// File: doc/BRIEF.md
# System Call Entry State Saver

This block prepares the architectural state that a 64-bit core writes when it takes a system call. Each request carries the address of the trapping instruction, the current machine state word, a supplied new machine state value, a supplied vectored target, and a bit that selects between the plain system call form and the vectored form. One clock after the request, the block presents a registered result set. That set holds the return address, the saved status word, the new machine state word and the next instruction address. It also raises write-enables for exactly those registers that the selected form changes.

The saved status word is a selective copy of the machine state word. Two bit ranges are forced to zero and every other bit passes through unchanged. For the plain form, the return address goes to save/restore register 0 and the status word goes to save/restore register 1. Control then moves to the fixed interrupt offset 0xC00. For the vectored form, the return address goes to the link register and the status word goes to the count register. Control then moves to the supplied target. Instruction decode, pipeline flushing and the rules that compute the new machine state all sit outside this block.

Top module: `sc_entry_saver`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` and all five write-enables (`srr0_we`, `srr1_we`, `lr_we`, `ctr_we`, `msr_we`) are 0.
- R2: A cycle with `req_valid`=1 produces `out_valid`=1 in the following cycle, and `out_valid`=0 in any cycle that follows a cycle with `req_valid`=0.
- R3: For a plain request (`req_vec`=0), the result cycle has `srr0_we`=1, `srr1_we`=1, `lr_we`=0 and `ctr_we`=0, and `ret_addr` equals `cur_ia`+4.
- R4: Bit numbering is big-endian: architectural bit k is LSB-0 bit 63-k. `stat_word` has architectural bits 33..36 (LSB-0 bits 30:27) and 42..47 (LSB-0 bits 21:16) equal to 0 for both forms.
- R5: Every other bit of `stat_word` (architectural 0..32, 37..41, 48..63) equals the same bit of the requesting cycle's `msr_cur`, for both forms.
- R6: For a plain request, `nia` equals 0x0000_0000_0000_0C00.
- R7: For a vectored request (`req_vec`=1), the result cycle has `lr_we`=1, `ctr_we`=1, `srr0_we`=0 and `srr1_we`=0, and `ret_addr` equals `cur_ia`+4.
- R8: For a vectored request, `nia` equals `vec_tgt`. For both forms, `msr_we`=1 and `msr_next` equals `msr_new`.
- R9: When `addr32_mode`=1, bits 63:32 of `ret_addr`, and of `nia` for a vectored request, are 0, while bits 31:0 are kept.
- R10: The return address wraps modulo 2^64: `cur_ia`=0xFFFF_FFFF_FFFF_FFFC yields `ret_addr`=0 in 64-bit mode.
- R11: Back-to-back requests of alternating forms each produce their own result in consecutive cycles, with no mixing of fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per system call |
| req_vec | input | 1 | 1 selects the vectored form, 0 the plain form |
| addr32_mode | input | 1 | 1 truncates computed addresses to 32 bits |
| cur_ia | input | 64 | Address of the system call instruction |
| msr_cur | input | 64 | Current machine state word |
| msr_new | input | 64 | New machine state word computed elsewhere |
| vec_tgt | input | 64 | Target address for the vectored form |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| srr0_we | output | 1 | Write save/restore register 0 with `ret_addr` |
| srr1_we | output | 1 | Write save/restore register 1 with `stat_word` |
| lr_we | output | 1 | Write link register with `ret_addr` |
| ctr_we | output | 1 | Write count register with `stat_word` |
| msr_we | output | 1 | Write machine state register with `msr_next` |
| ret_addr | output | 64 | Return address (instruction address + 4) |
| stat_word | output | 64 | Saved status word |
| msr_next | output | 64 | New machine state word |
| nia | output | 64 | Next instruction address |

## Verification
On every cycle, the assertions check several properties. The save/restore and the link/count enable pairs never both fire, and every enable stays inside a valid result. The forced-zero fields are zero and the copied fields match the machine state word of the previous cycle. A plain result always targets 0xC00, and the 32-bit mode truncation holds. Only the directed scenarios can show that the return address is really the instruction address plus four, including wraparound at the top of the address space. The same applies to the vectored target and new state word being passed through unchanged, and to alternating back-to-back requests keeping their fields apart.

// File: rtl/sc_entry_pkg.sv
package sc_entry_pkg;

  // Architectural (big-endian) bit ranges cleared in the saved status word.
  localparam int unsigned ZR_A_FIRST = 33;
  localparam int unsigned ZR_A_LAST  = 36;
  localparam int unsigned ZR_B_FIRST = 42;
  localparam int unsigned ZR_B_LAST  = 47;

  typedef enum logic {
    FORM_PLAIN = 1'b0,
    FORM_VECT  = 1'b1
  } sc_form_e;

  typedef struct packed {
    logic srr0;
    logic srr1;
    logic lr;
    logic ctr;
    logic msr;
  } sc_we_t;

  // True when big-endian bit k of the status word is forced to zero.
  function automatic logic be_bit_cleared(input int unsigned k);
    return ((k >= ZR_A_FIRST) && (k <= ZR_A_LAST)) ||
           ((k >= ZR_B_FIRST) && (k <= ZR_B_LAST));
  endfunction

  function automatic sc_we_t we_for_form(input sc_form_e f);
    sc_we_t w;
    w.msr  = 1'b1;
    w.srr0 = (f == FORM_PLAIN);
    w.srr1 = (f == FORM_PLAIN);
    w.lr   = (f == FORM_VECT);
    w.ctr  = (f == FORM_VECT);
    return w;
  endfunction

endpackage

// File: rtl/sc_ret_addr.sv
module sc_ret_addr #(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned NARROW_W   = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] ia,
  input  logic            narrow,
  output logic [XLEN-1:0] ret
);
  localparam logic [XLEN-1:0] STEP      = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] NARROW_MK = {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [XLEN-1:0] sum;

  always_comb begin
    sum = ia + STEP;
    ret = narrow ? (sum & NARROW_MK) : sum;
  end
endmodule

// File: rtl/sc_stat_merge.sv
module sc_stat_merge
  import sc_entry_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] msr_in,
  output logic [XLEN-1:0] stat_out
);
  function automatic logic [XLEN-1:0] build_keep();
    logic [XLEN-1:0] m;
    for (int unsigned k = 0; k < XLEN; k++) begin
      m[XLEN-1-k] = !be_bit_cleared(k);
    end
    return m;
  endfunction

  localparam logic [XLEN-1:0] KEEP = build_keep();

  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (KEEP[b]) begin : g_copy
      assign stat_out[b] = msr_in[b];
    end else begin : g_zero
      assign stat_out[b] = 1'b0;
    end
  end
endmodule

// File: rtl/sc_tgt_sel.sv
module sc_tgt_sel
  import sc_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned NARROW_W   = 32,
  parameter logic [15:0] VEC_OFFSET = 16'h0C00
) (
  input  sc_form_e        form,
  input  logic            narrow,
  input  logic [XLEN-1:0] vec_tgt,
  output logic [XLEN-1:0] tgt
);
  localparam logic [XLEN-1:0] NARROW_MK = {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [XLEN-1:0] FIXED_TGT = XLEN'(VEC_OFFSET);

  always_comb begin
    if (form == FORM_VECT) begin
      tgt = narrow ? (vec_tgt & NARROW_MK) : vec_tgt;
    end else begin
      tgt = FIXED_TGT;
    end
  end
endmodule

// File: rtl/sc_entry_saver.sv
module sc_entry_saver
  import sc_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned NARROW_W   = 32,
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [15:0] VEC_OFFSET = 16'h0C00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_vec,
  input  logic            addr32_mode,
  input  logic [XLEN-1:0] cur_ia,
  input  logic [XLEN-1:0] msr_cur,
  input  logic [XLEN-1:0] msr_new,
  input  logic [XLEN-1:0] vec_tgt,
  output logic            out_valid,
  output logic            srr0_we,
  output logic            srr1_we,
  output logic            lr_we,
  output logic            ctr_we,
  output logic            msr_we,
  output logic [XLEN-1:0] ret_addr,
  output logic [XLEN-1:0] stat_word,
  output logic [XLEN-1:0] msr_next,
  output logic [XLEN-1:0] nia
);
  localparam logic [XLEN-1:0] HI_MASK = ~{{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  sc_form_e        form_d;
  sc_we_t          we_d;
  sc_we_t          we_q;
  logic [XLEN-1:0] ret_d;
  logic [XLEN-1:0] stat_d;
  logic [XLEN-1:0] tgt_d;

  assign form_d = req_vec ? FORM_VECT : FORM_PLAIN;
  assign we_d   = we_for_form(form_d);

  sc_ret_addr #(
    .XLEN(XLEN), .NARROW_W(NARROW_W), .INSN_BYTES(INSN_BYTES)
  ) u_ret (
    .ia(cur_ia), .narrow(addr32_mode), .ret(ret_d)
  );

  sc_stat_merge #(.XLEN(XLEN)) u_stat (
    .msr_in(msr_cur), .stat_out(stat_d)
  );

  sc_tgt_sel #(
    .XLEN(XLEN), .NARROW_W(NARROW_W), .VEC_OFFSET(VEC_OFFSET)
  ) u_tgt (
    .form(form_d), .narrow(addr32_mode), .vec_tgt(vec_tgt), .tgt(tgt_d)
  );

  // Control path: strobe and enables, reset to idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      we_q      <= '0;
    end else begin
      out_valid <= req_valid;
      we_q      <= req_valid ? we_d : '0;
    end
  end

  // Data path: captured on each request, no reset needed.
  always_ff @(posedge clk) begin
    if (req_valid) begin
      ret_addr  <= ret_d;
      stat_word <= stat_d;
      msr_next  <= msr_new;
      nia       <= tgt_d;
    end
  end

  assign srr0_we = we_q.srr0;
  assign srr1_we = we_q.srr1;
  assign lr_we   = we_q.lr;
  assign ctr_we  = we_q.ctr;
  assign msr_we  = we_q.msr;

  // Assertions
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !msr_we && !srr0_we && !lr_we);

  p_we_inside_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (srr0_we || srr1_we || lr_we || ctr_we || msr_we) |-> out_valid);

  p_pair_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({srr0_we, lr_we}) && $onehot0({srr1_we, ctr_we}));

  p_zero_fields_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (stat_word[30:27] == 4'd0) && (stat_word[21:16] == 6'd0));

  p_copied_fields_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (stat_word[XLEN-1:31] == $past(msr_cur[XLEN-1:31])) &&
                  (stat_word[26:22] == $past(msr_cur[26:22])) &&
                  (stat_word[15:0] == $past(msr_cur[15:0])));

  p_plain_target_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && srr0_we) |-> nia == XLEN'(VEC_OFFSET));

  p_narrow_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(addr32_mode)) |-> ((ret_addr & HI_MASK) == '0) &&
                                          ((nia & HI_MASK) == '0));
endmodule

// File: tb/test_sc_entry_saver.sv
module test_sc_entry_saver;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, req_valid, req_vec, addr32_mode;
  logic [63:0] cur_ia, msr_cur, msr_new, vec_tgt;
  logic        out_valid, srr0_we, srr1_we, lr_we, ctr_we, msr_we;
  logic [63:0] ret_addr, stat_word, msr_next, nia;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_entry_saver i_sc_entry_saver (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
    .addr32_mode(addr32_mode), .cur_ia(cur_ia), .msr_cur(msr_cur),
    .msr_new(msr_new), .vec_tgt(vec_tgt), .out_valid(out_valid),
    .srr0_we(srr0_we), .srr1_we(srr1_we), .lr_we(lr_we), .ctr_we(ctr_we),
    .msr_we(msr_we), .ret_addr(ret_addr), .stat_word(stat_word),
    .msr_next(msr_next), .nia(nia)
  );

  function automatic logic [63:0] exp_stat(input logic [63:0] m);
    logic [63:0] r = m;
    for (int k = 33; k <= 36; k++) r[63-k] = 1'b0;
    for (int k = 42; k <= 47; k++) r[63-k] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive request at negedge; result appears after next posedge, sampled at following negedge.
  task automatic issue(input logic vec, input logic n32, input logic [63:0] ia,
                       input logic [63:0] mc, input logic [63:0] mn, input logic [63:0] vt);
    req_valid = 1'b1; req_vec = vec; addr32_mode = n32;
    cur_ia = ia; msr_cur = mc; msr_new = mn; vec_tgt = vt;
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_plain(input string tag, input logic n32, input logic [63:0] ia,
                             input logic [63:0] mc, input logic [63:0] mn);
    logic [63:0] r = ia + 64'd4;
    if (n32) r[63:32] = '0;
    chk({tag, " R2 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R3 enables"}, 64'({srr0_we, srr1_we, lr_we, ctr_we}), 64'b1100);
    chk({tag, " R3 ret_addr"}, ret_addr, r);
    chk({tag, " R4/R5 stat"}, stat_word, exp_stat(mc));
    chk({tag, " R6 nia"}, nia, 64'h0C00);
    chk({tag, " R8 msr"}, {63'd0, msr_we} ^ 64'd1 | (msr_next ^ mn), 64'd0);
  endtask

  task automatic check_vect(input string tag, input logic n32, input logic [63:0] ia,
                            input logic [63:0] mc, input logic [63:0] mn, input logic [63:0] vt);
    logic [63:0] r = ia + 64'd4;
    logic [63:0] t = vt;
    if (n32) begin r[63:32] = '0; t[63:32] = '0; end
    chk({tag, " R2 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R7 enables"}, 64'({srr0_we, srr1_we, lr_we, ctr_we}), 64'b0011);
    chk({tag, " R7 ret_addr"}, ret_addr, r);
    chk({tag, " R4/R5 stat"}, stat_word, exp_stat(mc));
    chk({tag, " R8 nia"}, nia, t);
    chk({tag, " R8 msr_we"}, 64'(msr_we), 64'd1);
    chk({tag, " R8 msr_next"}, msr_next, mn);
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b1; req_vec = 1'b0; addr32_mode = 1'b0;
    cur_ia = 64'h100; msr_cur = '1; msr_new = '0; vec_tgt = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", 64'({out_valid, srr0_we, srr1_we, lr_we, ctr_we, msr_we}), 64'd0);
    req_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 64'({out_valid, srr0_we, srr1_we, lr_we, ctr_we, msr_we}), 64'd0);
  endtask

  task automatic t_plain();
    issue(1'b0, 1'b0, 64'h0000_1234_5678_9AB0, 64'h8000_0001_F00F_0003, 64'h9000_0000_0000_1001, 64'hDEAD);
    check_plain("plain", 1'b0, 64'h0000_1234_5678_9AB0, 64'h8000_0001_F00F_0003, 64'h9000_0000_0000_1001);
    idle();
    chk("R2 no request", 64'({out_valid, msr_we}), 64'd0);
  endtask

  task automatic t_vect();
    issue(1'b1, 1'b0, 64'h0000_7FFF_0000_0040, 64'h0123_4567_89AB_CDEF, 64'hA5A5_0000_5A5A_0000, 64'hC000_0000_0001_7000);
    check_vect("vect", 1'b0, 64'h0000_7FFF_0000_0040, 64'h0123_4567_89AB_CDEF, 64'hA5A5_0000_5A5A_0000, 64'hC000_0000_0001_7000);
    idle();
  endtask

  task automatic t_fields();
    issue(1'b0, 1'b0, 64'h10, '1, '0, '0);
    chk("R4 zero fields", stat_word & 64'h0000_0000_783F_0000, 64'd0);
    chk("R5 kept ones", stat_word, 64'hFFFF_FFFF_87C0_FFFF);
    idle();
  endtask

  task automatic t_narrow();
    issue(1'b1, 1'b1, 64'hFFFF_0000_FFFF_FFFC, 64'h55, 64'h77, 64'hABCD_0000_1234_0000);
    check_vect("narrow vect R9", 1'b1, 64'hFFFF_0000_FFFF_FFFC, 64'h55, 64'h77, 64'hABCD_0000_1234_0000);
    chk("R9 ret high", ret_addr[63:32], 64'd0);
    idle();
    issue(1'b0, 1'b1, 64'h0000_0001_8000_0000, 64'h0, 64'h0, 64'h0);
    check_plain("narrow plain R9", 1'b1, 64'h0000_0001_8000_0000, 64'h0, 64'h0);
    idle();
  endtask

  task automatic t_wrap();
    issue(1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h0, 64'h0);
    chk("R10 wrap", ret_addr, 64'd0);
    idle();
  endtask

  task automatic t_back_to_back();
    issue(1'b0, 1'b0, 64'h2000, 64'hFFFF_0000_FFFF_0000, 64'h11, 64'h9999);
    check_plain("b2b first R11", 1'b0, 64'h2000, 64'hFFFF_0000_FFFF_0000, 64'h11);
    issue(1'b1, 1'b0, 64'h3000, 64'h0000_FFFF_0000_FFFF, 64'h22, 64'h8888);
    check_vect("b2b second R11", 1'b0, 64'h3000, 64'h0000_FFFF_0000_FFFF, 64'h22, 64'h8888);
    issue(1'b0, 1'b0, 64'h4000, 64'h1, 64'h33, 64'h7777);
    check_plain("b2b third R11", 1'b0, 64'h4000, 64'h1, 64'h33);
    idle();
    chk("R2 pulse ends", 64'(out_valid), 64'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_plain();
    t_vect();
    t_fields();
    t_narrow();
    t_wrap();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule